// File: doc/BRIEF.md
# Float Compare-Select Unit

This unit is one execution slot of a small single-precision microcoded vector processor. It handles the opcodes that need no arithmetic datapath. Each of these opcodes works on IEEE-754 words by bit manipulation only:

- copy
- absolute value
- ordered greater-than and equality tests, which give the float constants 1.0 or 0.0
- a flag-driven choice between the two operands
- sign transfer from the second operand to the first
- the magic-constant seed for a reciprocal square root

Each cycle the sequencer may present one operation. An operation is two 32-bit operands, the processor's 32-bit flags word and a 4-bit opcode, qualified by `valid_i`. The result comes back with a strobe a fixed two cycles later. A new operation can be issued every cycle. Opcodes that this slot does not execute are dropped, and they produce no strobe. The adder, multiplier, conversion and trigonometric slots handle their own opcodes.

Top module: `fcmp_sel_unit`

## Requirements
- R1: An operation accepted on the clock edge where `valid_i` is high and the opcode is supported gives `valid_o` high, with its result on `result_o`, after exactly two rising edges. Back-to-back operations come out back-to-back, in issue order.
- R2: The supported opcodes are 4 absolute value, 10 greater-than, 11 equality, 12 copy, 13 select, 14 sign transfer and 15 root seed. Opcode 0, opcodes 1 to 3 and opcodes 5 to 9 produce no `valid_o`. Any opcode presented with `valid_i` low also produces no `valid_o`.
- R3: `result_o` is all zeros in every cycle in which `valid_o` is low.
- R4: Copy (12) returns a unchanged. Absolute value (4) returns a with bit 31 cleared.
- R5: Greater-than (10) returns 0x3F800000 when a > b as floats, and 0x00000000 otherwise. Of two negative values, the one with the smaller magnitude is the greater. +0 and -0 are not greater than each other. Infinities order as ordinary values.
- R6: Equality (11) returns 0x3F800000 when a and b are equal as floats, and 0x00000000 otherwise. +0 equals -0.
- R7: A NaN is a word whose bits 30:23 are all ones and whose bits 22:0 are not all zero. When either operand is a NaN, greater-than and equality both return 0x00000000.
- R8: Select (13) returns a when any bit of the flags word is set, and b when the flags word is zero.
- R9: Sign transfer (14) returns a with bit 31 inverted when b is below zero, that is when b has its sign set, is not a zero and is not a NaN. Otherwise it returns a unchanged.
- R10: Root seed (15) returns 0x5F3759DF minus (a shifted right logically by one), modulo 2^32.
- R11: While `rst_ni` is low and after it is released, `valid_o` and `result_o` are zero until the first accepted operation reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Opcode |
| a_i | input | 32 | First operand (float bits) |
| b_i | input | 32 | Second operand (float bits) |
| flags_i | input | 32 | Processor flags word, used by select |
| valid_o | output | 1 | Result strobe |
| result_o | output | 32 | Result word, zero when not valid |

## Verification
The bench goes after the comparison corners. A signed-zero pair must compare equal and not greater; a comparator that only matched bit patterns would report them unequal. Negative pairs and infinities check the ordering; treating the sign bit as a magnitude bit would reverse the order of negative values. Quiet and signalling NaN operands must yield 0.0 from both tests; a comparator with no unordered case would return 1.0 for NaN equal to itself. Sign transfer is driven with a negative zero and with a negative NaN as b, which must leave a unchanged. The stream also mixes in every unsupported opcode and idle cycles carrying a supported opcode; a decoder with holes or a strobe that ignored `valid_i` would then emit results that do not exist.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NONE = 4'd0,
    OP_ABS  = 4'd4,
    OP_GT   = 4'd10,
    OP_EQ   = 4'd11,
    OP_MOV  = 4'd12,
    OP_SEL  = 4'd13,
    OP_SGN  = 4'd14,
    OP_RSQ  = 4'd15
  } op_e;
endpackage

// File: rtl/fcs_decode.sv
module fcs_decode
  import fcs_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output logic            ok_o
);
  always_comb begin
    case (op_i)
      OP_ABS, OP_GT, OP_EQ, OP_MOV, OP_SEL, OP_SGN, OP_RSQ: ok_o = 1'b1;
      default:                                              ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fcs_compare.sv
module fcs_compare #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a_i,
  input  logic [EXP_W+MAN_W:0] b_i,
  output logic                 gt_o,
  output logic                 eq_o
);
  localparam int unsigned W = EXP_W + MAN_W + 1;

  logic         sa, sb;
  logic [W-2:0] ma, mb;
  logic         nan_a, nan_b, zeros, mag_gt, mag_eq;

  assign sa     = a_i[W-1];
  assign sb     = b_i[W-1];
  assign ma     = a_i[W-2:0];
  assign mb     = b_i[W-2:0];
  assign nan_a  = (&ma[W-2 -: EXP_W]) & (|ma[MAN_W-1:0]);
  assign nan_b  = (&mb[W-2 -: EXP_W]) & (|mb[MAN_W-1:0]);
  assign zeros  = ~(|ma) & ~(|mb);
  assign mag_gt = ma > mb;
  assign mag_eq = ma == mb;

  // sign-magnitude ordering; negatives compare by reversed magnitude
  always_comb begin
    if (nan_a || nan_b) begin
      gt_o = 1'b0;
      eq_o = 1'b0;
    end else if (zeros) begin
      gt_o = 1'b0;
      eq_o = 1'b1;
    end else if (sa != sb) begin
      gt_o = ~sa;
      eq_o = 1'b0;
    end else if (!sa) begin
      gt_o = mag_gt;
      eq_o = mag_eq;
    end else begin
      gt_o = ~mag_gt & ~mag_eq;
      eq_o = mag_eq;
    end
  end
endmodule

// File: rtl/fcs_bitops.sv
module fcs_bitops
  import fcs_pkg::*;
#(
  parameter int unsigned          EXP_W  = 8,
  parameter int unsigned          MAN_W  = 23,
  parameter logic [EXP_W+MAN_W:0] SEED_K = 32'h5F3759DF
) (
  input  logic [OP_W-1:0]      op_i,
  input  logic [EXP_W+MAN_W:0] a_i,
  input  logic [EXP_W+MAN_W:0] b_i,
  input  logic [EXP_W+MAN_W:0] flags_i,
  input  logic                 gt_i,
  input  logic                 eq_i,
  output logic [EXP_W+MAN_W:0] res_o
);
  localparam int unsigned  W   = EXP_W + MAN_W + 1;
  localparam logic [W-1:0] ONE = {2'b00, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};

  logic b_nan, b_neg;

  assign b_nan = (&b_i[W-2 -: EXP_W]) & (|b_i[MAN_W-1:0]);
  assign b_neg = b_i[W-1] & (|b_i[W-2:0]) & ~b_nan;

  always_comb begin
    case (op_i)
      OP_ABS:  res_o = {1'b0, a_i[W-2:0]};
      OP_GT:   res_o = gt_i ? ONE : '0;
      OP_EQ:   res_o = eq_i ? ONE : '0;
      OP_MOV:  res_o = a_i;
      OP_SEL:  res_o = (|flags_i) ? a_i : b_i;
      OP_SGN:  res_o = b_neg ? {~a_i[W-1], a_i[W-2:0]} : a_i;
      OP_RSQ:  res_o = SEED_K - {1'b0, a_i[W-1:1]};
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/fcmp_sel_unit.sv
module fcmp_sel_unit
  import fcs_pkg::*;
#(
  parameter int unsigned          EXP_W  = 8,
  parameter int unsigned          MAN_W  = 23,
  parameter logic [EXP_W+MAN_W:0] SEED_K = 32'h5F3759DF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [OP_W-1:0]      op_i,
  input  logic [EXP_W+MAN_W:0] a_i,
  input  logic [EXP_W+MAN_W:0] b_i,
  input  logic [EXP_W+MAN_W:0] flags_i,
  output logic                 valid_o,
  output logic [EXP_W+MAN_W:0] result_o
);
  localparam int unsigned  W   = EXP_W + MAN_W + 1;
  localparam logic [W-1:0] ONE = {2'b00, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};

  logic            in_ok, take;
  logic            s1_valid;
  logic [OP_W-1:0] s1_op;
  logic [W-1:0]    s1_a, s1_b, s1_flags;
  logic            cmp_gt, cmp_eq;
  logic [W-1:0]    res;

  fcs_decode u_decode (
    .op_i (op_i),
    .ok_o (in_ok)
  );

  assign take = valid_i & in_ok;

  // stage 1: operand capture, unsupported opcodes dropped here
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_op    <= '0;
      s1_a     <= '0;
      s1_b     <= '0;
      s1_flags <= '0;
    end else begin
      s1_valid <= take;
      if (take) begin
        s1_op    <= op_i;
        s1_a     <= a_i;
        s1_b     <= b_i;
        s1_flags <= flags_i;
      end
    end
  end

  fcs_compare #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_compare (
    .a_i  (s1_a),
    .b_i  (s1_b),
    .gt_o (cmp_gt),
    .eq_o (cmp_eq)
  );

  fcs_bitops #(.EXP_W(EXP_W), .MAN_W(MAN_W), .SEED_K(SEED_K)) u_bitops (
    .op_i    (s1_op),
    .a_i     (s1_a),
    .b_i     (s1_b),
    .flags_i (s1_flags),
    .gt_i    (cmp_gt),
    .eq_i    (cmp_eq),
    .res_o   (res)
  );

  // stage 2: result register, forced quiet when idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o  <= s1_valid;
      result_o <= s1_valid ? res : '0;
    end
  end

  a_r1_two_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i, 2));

  a_r2_drop_unsupported: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !in_ok) |-> ##2 !valid_o);

  a_r3_quiet_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (result_o == '0));

  a_r4_abs_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(s1_op) == OP_ABS) |-> !result_o[W-1]);

  a_r5_cmp_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid |-> !(cmp_gt && cmp_eq));

  a_r6_cmp_const: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ($past(s1_op) == OP_GT || $past(s1_op) == OP_EQ))
      |-> (result_o == ONE || result_o == '0));
endmodule

// File: tb/fcmp_sel_unit_bench.sv
module fcmp_sel_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0, flags_i = '0;
  logic        valid_o;
  logic [31:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  fcmp_sel_unit u_fcmp_sel_unit (
    .clk_i (clk_i), .rst_ni (rst_ni), .valid_i (valid_i), .op_i (op_i),
    .a_i (a_i), .b_i (b_i), .flags_i (flags_i),
    .valid_o (valid_o), .result_o (result_o)
  );

  function automatic bit is_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic longint fkey(input logic [31:0] x);
    longint m = longint'(x[30:0]);
    return x[31] ? -m : m;
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd4, 4'd12: return "R4";
      4'd10:       return "R5/R7";
      4'd11:       return "R6/R7";
      4'd13:       return "R8";
      4'd14:       return "R9";
      4'd15:       return "R10";
      default:     return "R2";
    endcase
  endfunction

  // reference result; ok=0 means no strobe expected
  task automatic ref_op(input logic v, input logic [3:0] op, input logic [31:0] a, b, f,
                        output logic ok, output logic [31:0] r);
    bit unord = is_nan(a) || is_nan(b);
    ok = v;
    r  = 32'h0;
    case (op)
      4'd4:  r = a & 32'h7FFFFFFF;
      4'd10: r = (!unord && fkey(a) > fkey(b)) ? 32'h3F800000 : 32'h0;
      4'd11: r = (!unord && fkey(a) == fkey(b)) ? 32'h3F800000 : 32'h0;
      4'd12: r = a;
      4'd13: r = (f != 0) ? a : b;
      4'd14: r = (!is_nan(b) && fkey(b) < 0) ? (a ^ 32'h80000000) : a;
      4'd15: r = 32'h5F3759DF - (a >> 1);
      default: ok = 1'b0;
    endcase
    if (!ok) r = 32'h0;
  endtask

  logic        m1_v = 0, m2_v = 0;
  logic [31:0] m1_r = 0, m2_r = 0;
  logic [3:0]  m1_op = 0, m2_op = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    logic ok;
    logic [31:0] r;
    if (!rst_ni) begin
      m1_v <= 0; m2_v <= 0; m1_r <= 0; m2_r <= 0; m1_op <= 0; m2_op <= 0;
    end else begin
      ref_op(valid_i, op_i, a_i, b_i, flags_i, ok, r);
      m1_v <= ok; m1_r <= r; m1_op <= op_i;
      m2_v <= m1_v; m2_r <= m1_r; m2_op <= m1_op;
    end
  end

  always @(negedge clk_i) begin
    if (!done) begin
      checks++;
      if (!rst_ni) begin
        if (valid_o !== 1'b0 || result_o !== 32'h0) begin
          errors++;
          $display("FAIL R11 reset: valid=%b result=%h expected valid=0 result=0", valid_o, result_o);
        end
      end else if (valid_o !== m2_v) begin
        errors++;
        $display("FAIL R1/R2 op=%0d: valid=%b expected %b", m2_op, valid_o, m2_v);
      end else if (result_o !== m2_r) begin
        errors++;
        $display("FAIL %s op=%0d: result=%h expected %h", m2_v ? tag_of(m2_op) : "R3",
                 m2_op, result_o, m2_r);
      end
    end
  end

  task automatic drive(input logic v, input logic [3:0] op,
                       input logic [31:0] a, b, f = 32'h0);
    @(negedge clk_i);
    valid_i = v; op_i = op; a_i = a; b_i = b; flags_i = f;
  endtask

  function automatic logic [31:0] pick();
    logic [31:0] sp [12] = '{32'h0, 32'h80000000, 32'h3F800000, 32'hBF800000,
                             32'h7F800000, 32'hFF800000, 32'h7FC00000, 32'hFFC00001,
                             32'h40000000, 32'hC0000000, 32'h00000001, 32'h80000001};
    if ($urandom_range(1, 0) == 1) return sp[$urandom_range(11, 0)];
    return $urandom();
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);                          // R11 checked while held
    @(negedge clk_i) rst_ni = 1'b1;
    // R4 copy / abs
    drive(1, 4'd12, 32'hC0490FDB, 32'h0);
    drive(1, 4'd4,  32'hC0490FDB, 32'h0);
    // R5 ordering corners
    drive(1, 4'd10, 32'h80000000, 32'h00000000);
    drive(1, 4'd10, 32'hBF800000, 32'hC0000000);
    drive(1, 4'd10, 32'hC0000000, 32'hBF800000);
    drive(1, 4'd10, 32'h7F800000, 32'h7F7FFFFF);
    drive(1, 4'd10, 32'h3F800000, 32'hBF800000);
    // R6 signed zeros and equality
    drive(1, 4'd11, 32'h00000000, 32'h80000000);
    drive(1, 4'd11, 32'h3F800000, 32'h3F800000);
    // R7 NaN operands
    drive(1, 4'd11, 32'h7FC00000, 32'h7FC00000);
    drive(1, 4'd10, 32'h7F800001, 32'h00000000);
    drive(1, 4'd10, 32'h3F800000, 32'hFFC00000);
    // R8 select
    drive(1, 4'd13, 32'h11111111, 32'h22222222, 32'h80000000);
    drive(1, 4'd13, 32'h11111111, 32'h22222222, 32'h0);
    // R9 sign transfer
    drive(1, 4'd14, 32'h40400000, 32'hBF800000);
    drive(1, 4'd14, 32'h40400000, 32'h80000000);
    drive(1, 4'd14, 32'h40400000, 32'hFFC00000);
    // R10 root seed
    drive(1, 4'd15, 32'h40800000, 32'h0);
    drive(1, 4'd15, 32'hFFFFFFFF, 32'h0);
    // R2 unsupported and idle, R3 quiet output
    for (int k = 0; k < 10; k++) drive(1, k[3:0], 32'h3F800000, 32'h3F800000);
    drive(0, 4'd12, 32'h12345678, 32'h0);
    // R1 mixed back-to-back stream
    for (int k = 0; k < 3000; k++)
      drive($urandom_range(7, 0) != 0, 4'($urandom_range(15, 0)), pick(), pick(),
            ($urandom_range(1, 0) == 1) ? 32'h0 : (32'h1 << $urandom_range(31, 0)));
    drive(0, 4'd0, 32'h0, 32'h0);
    repeat (4) @(negedge clk_i);
    @(posedge clk_i);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule